// File: doc/BRIEF.md
# I2C Serial EEPROM Target (512 x 8)

This block is an I2C target that behaves like a 512-byte serial EEPROM held in an on-chip register array. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions and decodes the device-select byte. It drives SDA only through an open-drain output enable. Hosts can write one byte or a burst of up to 16 bytes into a page buffer. The buffered bytes are committed in a timed internal write cycle. Hosts can read from the current address, from an address they supply, or as a continuous sequential stream.

The protocol engine is a single state machine with these states:

- `ST_IDLE`: waiting for START.
- `ST_DEV`: shifting in the select byte.
- `ST_DEV_ACK`: acknowledging the select byte.
- `ST_ADDR`: shifting in the word address.
- `ST_ADDR_ACK`: acknowledging the word address.
- `ST_WR`: shifting in a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD`: shifting a data byte out.
- `ST_RD_ACK`: sampling the host's acknowledge.

The transitions are:

- START moves every state to `ST_DEV`.
- STOP moves every state to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on a select match while the block is not busy. Otherwise it goes to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RD` for a read or to `ST_ADDR` for a write.
- `ST_ADDR` goes to `ST_ADDR_ACK`, and `ST_ADDR_ACK` goes to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate.
- `ST_RD` goes to `ST_RD_ACK`. From `ST_RD_ACK` the block returns to `ST_RD` if the host acknowledged, and goes to `ST_IDLE` if it did not.

Each state change happens on a detected SCL falling edge.

The select byte carries address bit 8. The word address byte carries bits 7..0. A host polls for the end of a write cycle by sending the select byte repeatedly until it is acknowledged.

Top module: `i2ce_target`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0) and every array byte reads 0xFF.
- R2: The select byte is sent MSB first and has this layout:
  - bits 7..4 = 1010;
  - bits 3..2 = `strap_i[1:0]`;
  - bit 1 = memory address bit 8;
  - bit 0 = 1 for a read, 0 for a write.
  A matching byte is acknowledged. A byte that does not match is not acknowledged, and the block stays silent until the next START.
- R3: In a write, the word address and each data byte are acknowledged. The buffered bytes are committed on a STOP that directly follows an acknowledged data byte.
- R4: During a write, the low 4 address bits increment and wrap within the 16-byte page. Bytes beyond 16 overwrite earlier buffered bytes.
- R5: A commit starts a write cycle of `WR_CYCLES` system clocks. During the cycle the select byte is not acknowledged. After the cycle it is acknowledged again.
- R6: If `wp_i` is high at STOP and address bit 8 is 1, the data bytes are still acknowledged but nothing is committed and no write cycle starts. With `wp_i` low, or for addresses 0 to 255, writes complete normally.
- R7: A STOP in the middle of a data byte, or a START before the STOP, commits nothing and starts no write cycle.
- R8: A random read is a write-select byte and a word address, then a repeated START and a read-select byte. It returns the byte at that address, MSB first.
- R9: During a sequential read the address advances after every byte and wraps from 511 to 0, not at page boundaries. The read continues while the host acknowledges and ends when it does not, with SDA released.
- R10: A read select with no word address starts at the address that follows the last byte read, with bit 8 taken from the select byte.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Board strap address compared with select bits 3..2 |
| wp_i | input | 1 | Write protection for addresses 256 to 511 |

## Verification
The assertions assume that SCL stays low for more than three system clocks in each low phase. The block's reaction to a falling edge passes through two synchronizer stages and the state register, and only then appears on `sda_oe`. The host must also change SDA only while SCL is low, except at START and STOP, and must never stretch or glitch SCL. The bench host drives each quarter of an SCL bit for eight system clocks and moves SDA only in the low quarter. A behavioural model of the array, the page wrap and the address pointer predicts every acknowledge and data byte. A per-clock monitor checks the SDA discipline.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } i2ce_state_e;

    localparam logic [3:0] SEL_FAMILY = 4'b1010;
endpackage

// File: rtl/i2ce_line_sampler.sv
module i2ce_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_d    <= scl_sync[1];
            sda_d    <= sda_sync[1];
        end
    end

    assign sda_lvl   = sda_sync[1];
    assign scl_rise  = scl_sync[1] & ~scl_d;
    assign scl_fall  = ~scl_sync[1] & scl_d;
    assign start_det = scl_sync[1] & scl_d & sda_d & ~sda_sync[1];
    assign stop_det  = scl_sync[1] & scl_d & ~sda_d & sda_sync[1];
endmodule

// File: rtl/i2ce_store.sv
module i2ce_store #(
    parameter int DEPTH      = 512,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 600,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE_BYTES),
    localparam int TW = $clog2(WR_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [AW-PW-1:0]        page_sel,
    input  logic [PAGE_BYTES*8-1:0] wdata,
    input  logic [PAGE_BYTES-1:0]   wmask,
    input  logic [AW-1:0]           raddr,
    output logic [7:0]              rdata,
    output logic                    busy
);
    logic [7:0]    mem [DEPTH];
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wmask[i]) mem[{page_sel, PW'(i)}] <= wdata[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          tmr <= '0;
        else if (commit)     tmr <= TW'(WR_CYCLES);
        else if (tmr != '0)  tmr <= tmr - 1'b1;
    end

    assign busy  = (tmr != '0);
    assign rdata = mem[raddr];
endmodule

// File: rtl/i2ce_target.sv
module i2ce_target #(
    parameter int DEPTH      = 512,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 600,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i,
    input  logic       wp_i
);
    import i2ce_pkg::*;

    i2ce_state_e st_q, st_d;
    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]    shreg;
    logic [3:0]    bcnt;
    logic [AW-1:0] ptr;
    logic          a8_q, wrote_q, mack_q, commit_q, wr_busy;
    logic [PAGE_BYTES*8-1:0] pbuf;
    logic [PAGE_BYTES-1:0]   pmask;
    logic [7:0]    rdata;
    logic          sel_hit, recv_st, dev_ack_st, ack_st;

    i2ce_line_sampler samp_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ce_store #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) store_i (
        .clk(clk), .rst_n(rst_n), .commit(commit_q),
        .page_sel(ptr[AW-1:PW]), .wdata(pbuf), .wmask(pmask),
        .raddr(ptr), .rdata(rdata), .busy(wr_busy)
    );

    assign sel_hit = (shreg[7:4] == SEL_FAMILY) && (shreg[3:2] == strap_i);
    assign recv_st = (st_q == ST_DEV) || (st_q == ST_ADDR) || (st_q == ST_WR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (start_det)      st_d = ST_DEV;
        else if (stop_det)  st_d = ST_IDLE;
        else if (scl_fall) begin
            unique case (st_q)
                ST_IDLE:     st_d = ST_IDLE;
                ST_DEV:      if (bcnt == 4'd8) st_d = (sel_hit && !wr_busy) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  st_d = shreg[0] ? ST_RD : ST_ADDR;
                ST_ADDR:     if (bcnt == 4'd8) st_d = ST_ADDR_ACK;
                ST_ADDR_ACK: st_d = ST_WR;
                ST_WR:       if (bcnt == 4'd8) st_d = ST_WR_ACK;
                ST_WR_ACK:   st_d = ST_WR;
                ST_RD:       if (bcnt == 4'd7) st_d = ST_RD_ACK;
                ST_RD_ACK:   st_d = mack_q ? ST_RD : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    // datapath: shifter, bit counter, pointer, page buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0; bcnt <= '0; ptr <= '0; a8_q <= 1'b0;
            wrote_q <= 1'b0; mack_q <= 1'b0; commit_q <= 1'b0;
            pbuf <= '0; pmask <= '0;
        end else begin
            commit_q <= 1'b0;
            if (start_det) begin
                bcnt    <= '0;
                wrote_q <= 1'b0;
            end else if (stop_det) begin
                // commit only when STOP lands at the first bit slot after a data ACK
                commit_q <= (st_q == ST_WR) && (bcnt <= 4'd1) && wrote_q
                            && !(wp_i && ptr[AW-1]);
                wrote_q  <= 1'b0;
            end else begin
                if (scl_rise && recv_st) begin
                    shreg <= {shreg[6:0], sda_lvl};
                    bcnt  <= bcnt + 1'b1;
                end
                if (scl_rise && st_q == ST_RD_ACK) mack_q <= !sda_lvl;
                if (scl_fall) begin
                    unique case (st_q)
                        ST_DEV: if (bcnt == 4'd8) begin
                            bcnt <= '0;
                            if (st_d == ST_DEV_ACK) begin
                                a8_q <= shreg[1];
                                if (shreg[0]) ptr[AW-1] <= shreg[1];
                            end
                        end
                        ST_DEV_ACK: begin
                            bcnt <= '0;
                            if (shreg[0]) shreg <= rdata;
                        end
                        ST_ADDR: if (bcnt == 4'd8) begin
                            ptr   <= {a8_q, shreg};
                            pmask <= '0;
                            bcnt  <= '0;
                        end
                        ST_WR: if (bcnt == 4'd8) begin
                            pbuf[ptr[PW-1:0]*8 +: 8] <= shreg;
                            pmask[ptr[PW-1:0]]       <= 1'b1;
                            wrote_q                  <= 1'b1;
                            bcnt                     <= '0;
                        end
                        ST_WR_ACK: ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
                        ST_RD: begin
                            if (bcnt == 4'd7) begin
                                ptr  <= ptr + 1'b1;
                                bcnt <= '0;
                            end else begin
                                shreg <= {shreg[6:0], 1'b1};
                                bcnt  <= bcnt + 1'b1;
                            end
                        end
                        ST_RD_ACK: if (mack_q) shreg <= rdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // outputs
    always_comb begin
        dev_ack_st = (st_q == ST_DEV_ACK);
        ack_st     = dev_ack_st || (st_q == ST_ADDR_ACK) || (st_q == ST_WR_ACK);
        sda_oe     = ack_st || ((st_q == ST_RD) && !shreg[7]);
    end
endmodule

// File: rtl/i2ce_target_chk.sv
module i2ce_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       busy,
    input logic       stop_seen,
    input logic       dev_ack_st,
    input logic [5:0] sel_hi,
    input logic [1:0] strap
);
    // R11: output moves only during the SCL low phase
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> !scl_i);

    // R5: no select acknowledge while the write cycle runs
    a_r5_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dev_ack_st);

    // R3: a write cycle is only ever launched by a STOP
    a_r3_cycle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen, 2));

    // R2: select is acknowledged only with family code and matching straps
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack_st |-> (sel_hi == {4'b1010, strap}));
endmodule

bind i2ce_target i2ce_target_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .busy(wr_busy), .stop_seen(stop_det), .dev_ack_st(dev_ack_st),
    .sel_hi(shreg[7:2]), .strap(strap_i)
);

// File: tb/i2ce_target_tb_top.sv
module i2ce_target_tb_top;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic       sda_line;
    int         tests = 0;
    int         fails = 0;
    int         disc_err = 0;
    bit         done = 1'b0;
    logic [7:0] ref_mem [512];
    int         ref_ptr = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2ce_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .wp_i(wp)
    );

    // per-clock reference check of bus discipline (R11)
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && (sda_oe !== prev_oe)) disc_err++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic bit_in(output logic r);
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); r = sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bit_in(r);
            b = {b[6:0], r};
        end
        bit_out(!give_ack);
    endtask

    function automatic logic [7:0] sel(input logic a8, input logic rd);
        return {4'b1010, strap, a8, rd};
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 37) & 255);
    endfunction

    task automatic wr_burst(input string req, input int addr, input int n, input int seed);
        logic ack;
        bit   commit;
        commit = !(wp && addr[8]);
        bus_start();
        send_byte(sel(addr[8], 1'b0), ack); chk({req, " select ack"}, ack, 1);
        send_byte(addr[7:0], ack);          chk({req, " address ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(pat(seed, i), ack);
            chk({req, " data ack"}, ack, 1);
            if (commit) ref_mem[{addr[8:4], 4'((addr + i) & 15)}] = pat(seed, i);
        end
        bus_stop();
    endtask

    task automatic poll_ready(output int tries);
        logic ack;
        bit ok = 1'b0;
        tries = 0;
        while (!ok && tries < 60) begin
            bus_start();
            send_byte(sel(1'b0, 1'b0), ack);
            bus_stop();
            if (ack) ok = 1'b1;
            else     tries++;
        end
    endtask

    task automatic rd_rand(input string req, input int addr, input int n);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(sel(addr[8], 1'b0), ack); chk({req, " select ack"}, ack, 1);
        send_byte(addr[7:0], ack);          chk({req, " address ack"}, ack, 1);
        bus_start();
        send_byte(sel(addr[8], 1'b1), ack); chk({req, " read select ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk({req, " data"}, b, ref_mem[(addr + i) % 512]);
        end
        bus_stop();
        ref_ptr = (addr + n) % 512;
    endtask

    task automatic rd_cur(input string req, input logic a8, input int n);
        logic ack;
        logic [7:0] b;
        int p;
        p = {23'd0, a8, 8'(ref_ptr & 255)};
        bus_start();
        send_byte(sel(a8, 1'b1), ack); chk({req, " select ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk({req, " data"}, b, ref_mem[(p + i) % 512]);
        end
        bus_stop();
        ref_ptr = (p + n) % 512;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int   tries;
        logic ack;
        logic [7:0] b;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: released bus and erased array
        chk("R1 sda released", sda_oe, 0);
        rd_rand("R1", 0, 2);
        rd_rand("R1", 511, 1);

        // R2: strap mismatch is not acknowledged
        bus_start();
        send_byte({4'b1010, ~strap, 2'b00}, ack);
        chk("R2 mismatch nack", ack, 0);
        chk("R2 silent after mismatch", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(8'b0110_1000, ack);
        chk("R2 wrong family nack", ack, 0);
        bus_stop();

        // R3 and R5: byte write, busy polling
        wr_burst("R3", 5, 1, 11);
        poll_ready(tries);
        chk("R5 nack during write cycle", tries > 0, 1);
        chk("R5 ack after write cycle", tries < 60, 1);
        rd_rand("R3", 5, 1);

        // R2: address bit 8 travels in the select byte
        wr_burst("R2", 'h105, 1, 99);
        poll_ready(tries);
        rd_rand("R2 a8", 'h105, 1);
        rd_rand("R2 a8 low half intact", 5, 1);

        // R4: 20 bytes from page offset 12 wrap inside the page
        wr_burst("R4", 'h1C, 20, 50);
        poll_ready(tries);
        rd_rand("R4", 'h10, 16);
        rd_rand("R4 next page untouched", 'h20, 1);

        // R9: sequential read across page boundary and the array end
        wr_burst("R9", 'h1FC, 4, 7);
        poll_ready(tries);
        wr_burst("R9", 0, 4, 200);
        poll_ready(tries);
        rd_rand("R9 end wrap", 'h1FD, 6);
        rd_rand("R9 page cross", 'h1A, 8);

        // R10: current-address read continues after last byte read
        rd_cur("R10", 1'b0, 3);
        rd_rand("R10 setup", 'h1FE, 1);
        rd_cur("R10 a8 from select", 1'b1, 2);

        // R6: protected upper half
        wp = 1'b1;
        wr_burst("R6 upper", 'h150, 3, 33);
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        bus_stop();
        chk("R6 no write cycle", ack, 1);
        rd_rand("R6 upper unchanged", 'h150, 3);
        wr_burst("R6 lower", 'h30, 2, 77);
        poll_ready(tries);
        chk("R6 lower starts cycle", tries > 0, 1);
        rd_rand("R6 lower written", 'h30, 2);
        wp = 1'b0;

        // R7: STOP mid-byte after one full byte
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        send_byte(8'h40, ack);
        send_byte(8'h5A, ack);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bus_stop();
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        bus_stop();
        chk("R7 mid-byte stop no cycle", ack, 1);
        rd_rand("R7 mid-byte stop no commit", 'h40, 1);
        // R7: START before STOP
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        send_byte(8'h41, ack);
        send_byte(8'hA5, ack);
        bus_start();
        send_byte(sel(1'b0, 1'b0), ack);
        bus_stop();
        chk("R7 restart no cycle", ack, 1);
        rd_rand("R7 restart no commit", 'h41, 1);

        // R8: random read of earlier data
        rd_rand("R8", 'h105, 1);
        rd_rand("R8", 'h13, 1);

        // R9: after a NACKed last byte the bus is free
        chk("R9 released after nack", sda_oe, 0);

        // R11: per-clock discipline monitor
        chk("R11 sda_oe changes while scl high", disc_err, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule